// File: doc/BRIEF.md
# Complex Fixed-Point Multiply-Accumulate Array

This block is the arithmetic core of a streaming matrix-product engine for complex numbers. It holds a grid of complex multiply-accumulate lanes, eight rows by four columns by default. On every cycle in which accumulation is enabled, each row receives one multiplicand element that is shared by all lanes of that row. A single 128-bit word carries four multiplier elements, and each of them is shared by all lanes of its column. Every lane forms the complex product of its two operands and adds it to its own running real and imaginary sums. All 32 lanes do this in the same cycle.

Operands use 32-bit words with the real component in the high half and the imaginary component in the low half. Multiplicand components are signed values with 14 fractional bits, so 0x4000 means 1.0. Multiplier components are plain signed 16-bit values. Each real product is scaled back to the multiplier's scale before it is summed. The sums are kept with headroom. For readout, a row select chooses one row, and its four lanes are clipped to 16 bits and packed the same way as the operands. A clear input empties all sums between result tiles. Address generation, queues and stream sequencing belong to the surrounding engine.

Top module: `cmac_array`

## Requirements
- R1: Word format: bits [31:16] hold the real component and bits [15:0] the imaginary component. Row r's multiplicand is `a_row_i[32r+31:32r]`. Column c's multiplier is `b_blk_i[32c+31:32c]`. The readout of lane (selected row, c) is `rd_data_o[32c+31:32c]`.
- R2: Each lane adds re = (ar·br >>> 14) − (ai·bi >>> 14) and im = (ar·bi >>> 14) + (ai·br >>> 14). Every 32-bit signed product is shifted arithmetically (rounding toward minus infinity) before it is combined.
- R3: Lane (r, c) uses row r's multiplicand and column c's multiplier. All lanes update in the same cycle.
- R4: Operands sampled with `acc_en_i` high at clock edge E are added at edge E+2. They are visible on the readout after that edge and not before it.
- R5: Operands presented while `acc_en_i` is low leave every sum unchanged.
- R6: `clear_i` high at an edge zeroes every sum at that edge. A product that was due to be added at that same edge is dropped. Products due at later edges are added.
- R7: Sums are held as 24-bit two's-complement values. A running sum that passes the 16-bit range and comes back into it reads out exactly.
- R8: On readout, each component is clipped to the range −32768 to 32767. It reads 0x7FFF above that range and 0x8000 below it.
- R9: Reset (active low, asynchronous) zeroes every sum and drops every product in flight.
- R10: `rd_row_i` selects the row presented on `rd_data_o` without a clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero all sums at this edge |
| acc_en_i | input | 1 | Accept the operands of this cycle |
| a_row_i | input | 256 | One multiplicand word per row |
| b_blk_i | input | 128 | Four multiplier words, one per column |
| rd_row_i | input | 3 | Row chosen for readout |
| rd_data_o | output | 128 | Clipped sums of the chosen row, one word per column |

## Verification
Every sum can be seen at the ports. Selecting its row shows it in the same cycle, so a corrupted accumulator shows up as soon as its row is read. A fault in the product stages shows up in the read data exactly two edges after the operands were taken. A lane that reads the wrong row or column operand disagrees with the bench model only when operands differ across the grid, so part of the stimulus gives every lane distinct values. Missing headroom is only visible when a sum leaves the 16-bit range and then comes back into it, so that sequence is driven on purpose.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

   // How a wide sum is narrowed for readout
   typedef enum logic {
      PACK_WRAP = 1'b0,
      PACK_SAT  = 1'b1
   } pack_mode_e;

endpackage

// File: rtl/cmac_ctrl.sv
// Shared stage-valid pipeline: one pair of flops serves every lane.
module cmac_ctrl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic acc_en_i,
   output logic prod_v_o,
   output logic term_v_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prod_v_o <= 1'b0;
         term_v_o <= 1'b0;
      end else begin
         prod_v_o <= acc_en_i;
         term_v_o <= prod_v_o;
      end
   end

endmodule

// File: rtl/cmac_lane.sv
// One complex lane: four products, scaled terms, two accumulators.
module cmac_lane #(
   parameter int CW    = 16,
   parameter int AFRAC = 14,
   parameter int ACC_W = 24
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    ld_prod_i,
   input  logic                    ld_term_i,
   input  logic                    add_i,
   input  logic                    clear_i,
   input  logic [2*CW-1:0]         a_i,
   input  logic [2*CW-1:0]         b_i,
   output logic signed [ACC_W-1:0] re_o,
   output logic signed [ACC_W-1:0] im_o
);

   localparam int PW = 2 * CW;
   localparam int SW = PW - AFRAC;
   localparam int TW = SW + 1;

   logic signed [CW-1:0] ar, ai, br, bi;
   assign ar = a_i[2*CW-1:CW];
   assign ai = a_i[CW-1:0];
   assign br = b_i[2*CW-1:CW];
   assign bi = b_i[CW-1:0];

   // Stage 1: the four real products
   logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         p_rr <= '0;
         p_ii <= '0;
         p_ri <= '0;
         p_ir <= '0;
      end else if (ld_prod_i) begin
         p_rr <= PW'(ar) * PW'(br);
         p_ii <= PW'(ai) * PW'(bi);
         p_ri <= PW'(ar) * PW'(bi);
         p_ir <= PW'(ai) * PW'(br);
      end
   end

   // Each product is brought to the multiplier's scale on its own
   logic signed [SW-1:0] s_rr, s_ii, s_ri, s_ir;
   assign s_rr = SW'(p_rr >>> AFRAC);
   assign s_ii = SW'(p_ii >>> AFRAC);
   assign s_ri = SW'(p_ri >>> AFRAC);
   assign s_ir = SW'(p_ir >>> AFRAC);

   // Stage 2: one subtract and one add per lane
   logic signed [TW-1:0] t_re, t_im;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         t_re <= '0;
         t_im <= '0;
      end else if (ld_term_i) begin
         t_re <= TW'(s_rr) - TW'(s_ii);
         t_im <= TW'(s_ri) + TW'(s_ir);
      end
   end

   // Accumulators; clear wins over an arriving term
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         re_o <= '0;
         im_o <= '0;
      end else if (clear_i) begin
         re_o <= '0;
         im_o <= '0;
      end else if (add_i) begin
         re_o <= re_o + ACC_W'(t_re);
         im_o <= im_o + ACC_W'(t_im);
      end
   end

endmodule

// File: rtl/cmac_pack.sv
// Narrows one lane's sums to a packed output word.
module cmac_pack
   import cmac_pkg::*;
#(
   parameter int         CW    = 16,
   parameter int         ACC_W = 24,
   parameter pack_mode_e MODE  = PACK_SAT
) (
   input  logic signed [ACC_W-1:0] re_i,
   input  logic signed [ACC_W-1:0] im_i,
   output logic [2*CW-1:0]         word_o
);

   localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (CW - 1)) - 1);
   localparam logic signed [ACC_W-1:0] LO = -HI - 1;

   generate
      if (MODE == PACK_SAT) begin : g_sat
         function automatic logic [CW-1:0] clip(input logic signed [ACC_W-1:0] v);
            if (v > HI)      return {1'b0, {(CW-1){1'b1}}};
            else if (v < LO) return {1'b1, {(CW-1){1'b0}}};
            else             return v[CW-1:0];
         endfunction
         assign word_o = {clip(re_i), clip(im_i)};
      end else begin : g_wrap
         assign word_o = {re_i[CW-1:0], im_i[CW-1:0]};
      end
   endgenerate

endmodule

// File: rtl/cmac_array.sv
// Grid of complex MAC lanes with row-broadcast A and column-shared B.
module cmac_array
   import cmac_pkg::*;
#(
   parameter int         ROWS   = 8,
   parameter int         COLS   = 4,
   parameter int         CW     = 16,
   parameter int         AFRAC  = 14,
   parameter int         ACC_W  = 24,
   parameter pack_mode_e PACK   = PACK_SAT,
   localparam int        EW     = 2 * CW,
   localparam int        RSEL_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 clear_i,
   input  logic                 acc_en_i,
   input  logic [ROWS*EW-1:0]   a_row_i,
   input  logic [COLS*EW-1:0]   b_blk_i,
   input  logic [RSEL_W-1:0]    rd_row_i,
   output logic [COLS*EW-1:0]   rd_data_o
);

   localparam int TERM_W = 2 * CW - AFRAC + 1;
   localparam int LANES  = ROWS * COLS;

   // Elaboration-time parameter checks
   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("cmac_array: ROWS must be at least 2");
      end
      if (COLS < 1) begin : g_bad_cols
         $error("cmac_array: COLS must be at least 1");
      end
      if (AFRAC < 0 || AFRAC >= 2 * CW) begin : g_bad_frac
         $error("cmac_array: AFRAC out of range for CW");
      end
      if (ACC_W < TERM_W || ACC_W < CW) begin : g_bad_acc
         $error("cmac_array: ACC_W too narrow for one scaled term");
      end
   endgenerate

   logic prod_v, term_v;

   cmac_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .acc_en_i (acc_en_i),
      .prod_v_o (prod_v),
      .term_v_o (term_v)
   );

   logic [LANES*ACC_W-1:0] acc_re_flat;
   logic [LANES*ACC_W-1:0] acc_im_flat;

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         for (genvar c = 0; c < COLS; c++) begin : g_col
            cmac_lane #(
               .CW    (CW),
               .AFRAC (AFRAC),
               .ACC_W (ACC_W)
            ) u_lane (
               .clk_i     (clk_i),
               .rst_ni    (rst_ni),
               .ld_prod_i (acc_en_i),
               .ld_term_i (prod_v),
               .add_i     (term_v),
               .clear_i   (clear_i),
               .a_i       (a_row_i[r*EW +: EW]),
               .b_i       (b_blk_i[c*EW +: EW]),
               .re_o      (acc_re_flat[(r*COLS+c)*ACC_W +: ACC_W]),
               .im_o      (acc_im_flat[(r*COLS+c)*ACC_W +: ACC_W])
            );
         end
      end

      // Row select first, then one narrowing unit per column
      for (genvar c = 0; c < COLS; c++) begin : g_rd
         logic signed [ACC_W-1:0] sel_re, sel_im;

         always_comb begin
            sel_re = '0;
            sel_im = '0;
            for (int r = 0; r < ROWS; r++) begin
               if (rd_row_i == RSEL_W'(r)) begin
                  sel_re = acc_re_flat[(r*COLS+c)*ACC_W +: ACC_W];
                  sel_im = acc_im_flat[(r*COLS+c)*ACC_W +: ACC_W];
               end
            end
         end

         cmac_pack #(
            .CW    (CW),
            .ACC_W (ACC_W),
            .MODE  (PACK)
         ) u_pack (
            .re_i   (sel_re),
            .im_i   (sel_im),
            .word_o (rd_data_o[c*EW +: EW])
         );
      end
   endgenerate

endmodule

// File: rtl/cmac_array_chk.sv
module cmac_array_chk
   import cmac_pkg::*;
#(
   parameter int         ROWS   = 8,
   parameter int         COLS   = 4,
   parameter int         CW     = 16,
   parameter int         ACC_W  = 24,
   parameter int         RSEL_W = 3,
   parameter pack_mode_e PACK   = PACK_SAT
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        clear_i,
   input logic                        term_v_i,
   input logic [RSEL_W-1:0]           rd_row_i,
   input logic [COLS*2*CW-1:0]        rd_data_i,
   input logic [ROWS*COLS*ACC_W-1:0]  acc_re_i,
   input logic [ROWS*COLS*ACC_W-1:0]  acc_im_i
);

   localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (CW - 1)) - 1);
   localparam logic signed [ACC_W-1:0] LO = -HI - 1;

   // Column 0 of the selected row, taken straight from the lane state
   logic signed [ACC_W-1:0] c0_re, c0_im;
   always_comb begin
      c0_re = '0;
      c0_im = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (rd_row_i == RSEL_W'(r)) begin
            c0_re = acc_re_i[(r*COLS)*ACC_W +: ACC_W];
            c0_im = acc_im_i[(r*COLS)*ACC_W +: ACC_W];
         end
      end
   end

   AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (acc_re_i == '0 && acc_im_i == '0)); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i && !term_v_i) |=> ($stable(acc_re_i) && $stable(acc_im_i))); // R5

   AST_IN_RANGE_RE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c0_re <= HI && c0_re >= LO) |-> (rd_data_i[2*CW-1:CW] == c0_re[CW-1:0])); // R1

   AST_IN_RANGE_IM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c0_im <= HI && c0_im >= LO) |-> (rd_data_i[CW-1:0] == c0_im[CW-1:0])); // R1

   generate
      if (PACK == PACK_SAT) begin : g_sat_chk
         AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (c0_re > HI) |-> (rd_data_i[2*CW-1:CW] == {1'b0, {(CW-1){1'b1}}})); // R8

         AST_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (c0_im < LO) |-> (rd_data_i[CW-1:0] == {1'b1, {(CW-1){1'b0}}})); // R8
      end
   endgenerate

endmodule

bind cmac_array cmac_array_chk #(
   .ROWS   (ROWS),
   .COLS   (COLS),
   .CW     (CW),
   .ACC_W  (ACC_W),
   .RSEL_W (RSEL_W),
   .PACK   (PACK)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .clear_i   (clear_i),
   .term_v_i  (term_v),
   .rd_row_i  (rd_row_i),
   .rd_data_i (rd_data_o),
   .acc_re_i  (acc_re_flat),
   .acc_im_i  (acc_im_flat)
);

// File: tb/cmac_array_tb_top.sv
`timescale 1ns/100ps
module cmac_array_tb_top;

   localparam int ROWS = 8;
   localparam int COLS = 4;
   localparam int EW   = 32;

   logic                 clk    = 1'b0;
   logic                 rst_n  = 1'b0;
   logic                 clear  = 1'b0;
   logic                 acc_en = 1'b0;
   logic [ROWS*EW-1:0]   a_row  = '0;
   logic [COLS*EW-1:0]   b_blk  = '0;
   logic [2:0]           rd_row = '0;
   logic [COLS*EW-1:0]   rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int m_re [ROWS][COLS];
   int m_im [ROWS][COLS];

   always #4 clk = ~clk;

   cmac_array dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .clear_i   (clear),
      .acc_en_i  (acc_en),
      .a_row_i   (a_row),
      .b_blk_i   (b_blk),
      .rd_row_i  (rd_row),
      .rd_data_o (rd_data)
   );

   // {A element, B element, expected lane word after one product}
   localparam logic [95:0] VEC [8] = '{
      {32'h4000_0000, 32'h0064_FFCE, 32'h0064_FFCE},
      {32'h0000_4000, 32'h0064_FFCE, 32'h0032_0064},
      {32'hC000_0000, 32'h0007_0003, 32'hFFF9_FFFD},
      {32'h2000_2000, 32'h0003_0005, 32'hFFFF_0003},
      {32'h2000_0000, 32'hFFFD_0000, 32'hFFFE_0000},
      {32'h7FFF_7FFF, 32'h7FFF_8000, 32'h7FFF_FFFE},
      {32'h8000_0000, 32'h7FFF_0000, 32'h8000_0000},
      {32'h4000_4000, 32'h1000_2000, 32'hF000_3000}
   };

   function automatic int wrap24(input int x);
      logic signed [23:0] t;
      t = x[23:0];
      return int'(t);
   endfunction

   function automatic logic [15:0] sat16(input int x);
      if (x > 32767)  return 16'h7FFF;
      if (x < -32768) return 16'h8000;
      return x[15:0];
   endfunction

   function automatic int hi16(input logic [31:0] w);
      return int'($signed(w[31:16]));
   endfunction

   function automatic int lo16(input logic [31:0] w);
      return int'($signed(w[15:0]));
   endfunction

   task automatic model_clear();
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) begin
            m_re[r][c] = 0;
            m_im[r][c] = 0;
         end
   endtask

   // R2/R3: lane (r,c) takes row r's A and column c's B
   task automatic model_add();
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) begin
            int ar, ai, br, bi;
            ar = hi16(a_row[r*EW +: EW]);
            ai = lo16(a_row[r*EW +: EW]);
            br = hi16(b_blk[c*EW +: EW]);
            bi = lo16(b_blk[c*EW +: EW]);
            m_re[r][c] = wrap24(m_re[r][c] + ((ar * br) >>> 14) - ((ai * bi) >>> 14));
            m_im[r][c] = wrap24(m_im[r][c] + ((ar * bi) >>> 14) + ((ai * br) >>> 14));
         end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue();
      model_add();
      acc_en = 1'b1;
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   task automatic hw_clear();
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      model_clear();
   endtask

   task automatic check_model(input string tag);
      for (int r = 0; r < ROWS; r++) begin
         bit ok;
         ok = 1'b1;
         rd_row = 3'(r);
         #0.4;
         for (int c = 0; c < COLS; c++) begin
            logic [31:0] exp_w;
            exp_w = {sat16(m_re[r][c]), sat16(m_im[r][c])};
            if (rd_data[c*EW +: EW] !== exp_w) begin
               ok = 1'b0;
               $display("FAIL %s row %0d lane %0d: actual %h expected %h",
                        tag, r, c, rd_data[c*EW +: EW], exp_w);
            end
         end
         n_chk++;
         if (!ok) n_bad++;
      end
   endtask

   task automatic check_const(input logic [31:0] exp_w, input string tag);
      for (int r = 0; r < ROWS; r++) begin
         bit ok;
         ok = 1'b1;
         rd_row = 3'(r);
         #0.4;
         for (int c = 0; c < COLS; c++) begin
            if (rd_data[c*EW +: EW] !== exp_w) begin
               ok = 1'b0;
               $display("FAIL %s row %0d lane %0d: actual %h expected %h",
                        tag, r, c, rd_data[c*EW +: EW], exp_w);
            end
         end
         n_chk++;
         if (!ok) n_bad++;
      end
   endtask

   task automatic check_lane0(input logic [31:0] exp_w, input string tag);
      rd_row = 3'd0;
      #0.4;
      n_chk++;
      if (rd_data[31:0] !== exp_w) begin
         n_bad++;
         $display("FAIL %s row 0 lane 0: actual %h expected %h", tag, rd_data[31:0], exp_w);
      end
   endtask

   task automatic load_uniform(input logic [31:0] a, input logic [31:0] b);
      a_row = {ROWS{a}};
      b_blk = {COLS{b}};
   endtask

   task automatic load_random();
      for (int r = 0; r < ROWS; r++) a_row[r*EW +: EW] = $urandom;
      for (int c = 0; c < COLS; c++) b_blk[c*EW +: EW] = $urandom;
   endtask

   initial begin
      model_clear();
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R9: sums are zero out of reset
      check_model("R9 reset state");

      // R1 R2 R8: table of single products, every lane identical
      for (int i = 0; i < 8; i++) begin
         hw_clear();
         load_uniform(VEC[i][95:64], VEC[i][63:32]);
         issue();
         tick(2);
         check_const(VEC[i][31:0], $sformatf("R2 vector %0d", i));
      end

      // R4: value absent after one edge, present after two
      hw_clear();
      load_uniform(32'h4000_0000, 32'h0005_0009);
      issue();
      tick(1);
      check_lane0(32'h0000_0000, "R4 early");
      tick(1);
      check_lane0(32'h0005_0009, "R4 on time");

      // R3 R10: distinct operands per lane, back to back
      hw_clear();
      for (int k = 0; k < 6; k++) begin
         load_random();
         issue();
      end
      tick(2);
      check_model("R3 distinct lanes");

      // R6: term due at the clear edge dropped, next term kept
      hw_clear();
      load_uniform(32'h4000_0000, 32'h0011_0022);
      acc_en = 1'b1;
      @(negedge clk);
      load_uniform(32'h4000_0000, 32'h0003_0004);
      @(negedge clk);
      acc_en = 1'b0;
      clear  = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      model_clear();
      model_add();
      tick(1);
      check_model("R6 clear drops arriving term");

      // R8: sums beyond 16 bits clip on readout
      hw_clear();
      load_uniform(32'h4000_0000, {16'sd30000, -16'sd30000});
      issue();
      issue();
      tick(2);
      check_const(32'h7FFF_8000, "R8 clip");

      // R7: headroom, sum returns into range
      load_uniform(32'h4000_0000, {-16'sd30000, 16'sd30000});
      issue();
      tick(2);
      check_const(32'h7530_8AD0, "R7 headroom");

      // R5: operands with acc_en low have no effect
      for (int k = 0; k < 4; k++) begin
         load_random();
         tick(1);
      end
      tick(2);
      check_const(32'h7530_8AD0, "R5 gated");

      // R9: reset mid-run empties sums
      load_random();
      model_add();
      acc_en = 1'b1;
      @(negedge clk);
      acc_en = 1'b0;
      rst_n  = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_clear();
      tick(3);
      check_model("R9 reset mid-run");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R4: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule